// File: doc/BRIEF.md
# Three-Window Address Translator

This block maps 32-bit addresses from an on-chip memory-mapped bus onto a remote 32-bit address space. It holds three windows. Each window has a base, a high address and a translation value. An address is compared with every window at once. When it lands inside a window, its low bits pass through unchanged and its upper bits are taken from that window's translation value. The number of low bits that pass through is set by each window's own size. A 64 KB window keeps 16 low bits and a 32 MB window keeps 25, so the number of upper bits replaced differs from window to window.

Addresses enter through a valid/ready handshake and leave one cycle later from a single register stage. The output carries the translated address, a hit flag, a miss flag and the number of the window that matched. Windows must be a power of two in size and aligned to that size. They start from parameter values at reset and can be rewritten through a small write port. The write port accepts a write only while no translation is pending.

Top module: `addr_xlate_win`

## Requirements
- R1: During and after reset, `out_valid` is 0 and `in_ready` is 1.
- R2: An address `a` hits window `w` when `base[w] <= a <= high[w]`. The pass-through mask is `m = high[w] ^ base[w]`, and the output address is `(a & m) | (xlat[w] & ~m)`. Bits of `xlat[w]` under the mask have no effect.
- R3: When an address lies in more than one window, the lowest-numbered window supplies the result and `out_win`.
- R4: An address that hits no window gives `out_miss`=1, `out_hit`=0, `out_addr`=0 and `out_win`=0.
- R5: An address accepted on a clock edge (`in_valid` and `in_ready` both high) appears with `out_valid`=1 right after that same edge.
- R6: While `out_valid`=1 and `out_ready`=0, `in_ready` is 0 and every output holds its value.
- R7: A write with `cfg_we`=1 updates one field of window `cfg_win`. The field is chosen by `cfg_sel`: 0 selects base, 1 selects high and 2 selects the translation value. The new value applies to every address accepted after the write edge.
- R8: A write attempted while `in_valid` or `out_valid` is high is dropped, and the window keeps its old value.
- R9: The base and high addresses of a window both hit. The address just below the base and the address just above the high address miss, provided no other window covers them.
- R10: On a hit, `out_win` gives the number of the matching window, and exactly one of `out_hit` and `out_miss` is set whenever `out_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input address valid |
| in_ready | output | 1 | Block can accept an address |
| in_addr | input | 32 | Local-side address |
| out_valid | output | 1 | Translated result valid |
| out_ready | input | 1 | Consumer takes the result |
| out_addr | output | 32 | Remote-side address, zero on miss |
| out_hit | output | 1 | Address matched a window |
| out_miss | output | 1 | Address matched no window |
| out_win | output | 2 | Index of the matching window |
| cfg_we | input | 1 | Window field write strobe |
| cfg_win | input | 2 | Window being written |
| cfg_sel | input | 2 | Field select: 0 base, 1 high, 2 translation |
| cfg_wdata | input | 32 | Value to write |

## Verification
Some properties are checked on every cycle. The output holds still under backpressure, and `in_ready` drops whenever a result is stalled. A miss always reads as a zero address. Hit and miss are never set together, and each accepted address produces a valid result on the next edge. Other behaviour can only be shown by the bench's scenarios, because it depends on the values stored in the windows. This covers the bit substitution of each window size, the boundary addresses of each window, overlap priority, the effect of a window rewrite, and a rewrite dropped while a result was pending.

// File: rtl/addr_xlate_win.sv
module addr_xlate_win #(
  parameter int NWIN = 3,
  parameter int AW = 32,
  parameter logic [NWIN*AW-1:0] RST_BASE = {32'hFE000000, 32'hABCDE000, 32'h12340000},
  parameter logic [NWIN*AW-1:0] RST_HIGH = {32'hFFFFFFFF, 32'hABCDFFFF, 32'h1234FFFF},
  parameter logic [NWIN*AW-1:0] RST_XLAT = {32'h40ABCDEF, 32'hFEDC0ABC, 32'h5671BEEF},
  localparam int IW = (NWIN > 1) ? $clog2(NWIN) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [AW-1:0] in_addr,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [AW-1:0] out_addr,
  output logic          out_hit,
  output logic          out_miss,
  output logic [IW-1:0] out_win,
  input  logic          cfg_we,
  input  logic [IW-1:0] cfg_win,
  input  logic [1:0]    cfg_sel,
  input  logic [AW-1:0] cfg_wdata
);

  logic [AW-1:0] base_q [NWIN];
  logic [AW-1:0] high_q [NWIN];
  logic [AW-1:0] xlat_q [NWIN];

  logic          hit_c;
  logic [IW-1:0] win_c;
  logic [AW-1:0] res_c;

  assign in_ready = !out_valid || out_ready;

  wire accept  = in_valid && in_ready;
  wire cfg_ok  = cfg_we && !in_valid && !out_valid && (int'(cfg_win) < NWIN);

  always_comb begin
    hit_c = 1'b0;
    win_c = '0;
    res_c = '0;
    for (int i = NWIN - 1; i >= 0; i--) begin
      if (in_addr >= base_q[i] && in_addr <= high_q[i]) begin
        hit_c = 1'b1;
        win_c = IW'(i);
        res_c = (in_addr & (high_q[i] ^ base_q[i])) |
                (xlat_q[i] & ~(high_q[i] ^ base_q[i]));
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NWIN; i++) begin
        base_q[i] <= RST_BASE[i*AW +: AW];
        high_q[i] <= RST_HIGH[i*AW +: AW];
        xlat_q[i] <= RST_XLAT[i*AW +: AW];
      end
    end else if (cfg_ok) begin
      case (cfg_sel)
        2'd0: base_q[cfg_win] <= cfg_wdata;
        2'd1: high_q[cfg_win] <= cfg_wdata;
        2'd2: xlat_q[cfg_win] <= cfg_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_addr  <= '0;
      out_hit   <= 1'b0;
      out_miss  <= 1'b0;
      out_win   <= '0;
    end else if (accept) begin
      out_valid <= 1'b1;
      out_addr  <= res_c;
      out_hit   <= hit_c;
      out_miss  <= !hit_c;
      out_win   <= win_c;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/addr_xlate_win_chk.sv
module addr_xlate_win_chk #(
  parameter int AW = 32,
  parameter int IW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [AW-1:0] out_addr,
  input logic          out_hit,
  input logic          out_miss,
  input logic [IW-1:0] out_win
);

  // R1
  idle_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  // R4
  miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_miss |-> out_addr == '0 && out_win == '0);

  // R5
  one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_addr) &&
      $stable(out_hit) && $stable(out_miss) && $stable(out_win));

  // R6
  stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  // R10
  hit_xor_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_hit != out_miss);

endmodule

bind addr_xlate_win addr_xlate_win_chk #(.AW(AW), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr),
  .out_hit(out_hit), .out_miss(out_miss), .out_win(out_win)
);

// File: tb/tb_addr_xlate_win.sv
`timescale 1ns/1ps
module tb_addr_xlate_win;
  logic clk = 0, rst_n = 0;
  logic in_valid = 0, out_ready = 1;
  logic [31:0] in_addr = 0;
  logic in_ready, out_valid, out_hit, out_miss;
  logic [31:0] out_addr;
  logic [1:0] out_win;
  logic cfg_we = 0;
  logic [1:0] cfg_win = 0, cfg_sel = 0;
  logic [31:0] cfg_wdata = 0;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  addr_xlate_win dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_addr(in_addr), .out_valid(out_valid), .out_ready(out_ready),
    .out_addr(out_addr), .out_hit(out_hit), .out_miss(out_miss),
    .out_win(out_win), .cfg_we(cfg_we), .cfg_win(cfg_win),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata)
  );

  // {in_addr, exp_addr, exp_hit, exp_win}
  localparam int NV = 12;
  localparam logic [66:0] VEC [NV] = '{
    {32'h12340ABC, 32'h56710ABC, 1'b1, 2'd0},
    {32'hABCDF123, 32'hFEDC1123, 1'b1, 2'd1},
    {32'hFFFEDCBA, 32'h41FEDCBA, 1'b1, 2'd2},
    {32'h12340000, 32'h56710000, 1'b1, 2'd0},
    {32'h1234FFFF, 32'h5671FFFF, 1'b1, 2'd0},
    {32'h1233FFFF, 32'h00000000, 1'b0, 2'd0},
    {32'h12350000, 32'h00000000, 1'b0, 2'd0},
    {32'hABCDE000, 32'hFEDC0000, 1'b1, 2'd1},
    {32'hABCDDFFF, 32'h00000000, 1'b0, 2'd0},
    {32'hFE000000, 32'h40000000, 1'b1, 2'd2},
    {32'hFFFFFFFF, 32'h41FFFFFF, 1'b1, 2'd2},
    {32'h00000000, 32'h00000000, 1'b0, 2'd0}
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic xlate(input logic [31:0] a, input logic [31:0] ea,
                       input logic eh, input logic [1:0] ew, input string tag);
    @(negedge clk);
    in_addr = a; in_valid = 1; out_ready = 1;
    @(negedge clk);
    in_valid = 0;
    check({tag, " valid"}, {63'd0, out_valid}, 64'd1);
    check({tag, " result"}, {29'd0, out_addr, eh ? 1'b1 : 1'b0, out_miss, out_win},
          {29'd0, ea, eh, !eh, ew});
    if (out_hit !== eh) check({tag, " hit"}, {63'd0, out_hit}, {63'd0, eh});
  endtask

  task automatic cfg(input logic [1:0] w, input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_win = w; cfg_sel = s; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #3;
    check("R1 reset valid", {63'd0, out_valid}, 64'd0);
    check("R1 reset ready", {63'd0, in_ready}, 64'd1);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 after reset", {62'd0, out_valid, in_ready}, 64'd1);

    // R2 R4 R9 R10: table walk
    for (int i = 0; i < NV; i++)
      xlate(VEC[i][66:35], VEC[i][34:3], VEC[i][2], VEC[i][1:0], $sformatf("R2/R4/R9 vec%0d", i));

    // R5: output appears after the accepting edge
    @(negedge clk);
    check("R5 idle before", {63'd0, out_valid}, 64'd0);
    xlate(32'h12341234, 32'h56711234, 1'b1, 2'd0, "R5");

    // R6: backpressure
    @(negedge clk);
    out_ready = 0; in_addr = 32'hABCDE456; in_valid = 1;
    @(negedge clk);
    in_addr = 32'h12340001;
    check("R6 first", {31'd0, out_addr, out_valid}, {31'd0, 32'hFEDC0456, 1'b1});
    check("R6 ready low", {63'd0, in_ready}, 64'd0);
    @(negedge clk);
    check("R6 held", {31'd0, out_addr, out_valid}, {31'd0, 32'hFEDC0456, 1'b1});
    // R8: write during pending result is dropped
    cfg_we = 1; cfg_win = 0; cfg_sel = 2; cfg_wdata = 32'h99990000;
    @(negedge clk);
    cfg_we = 0; out_ready = 1;
    @(negedge clk);
    in_valid = 0;
    check("R6 next", {31'd0, out_addr, out_valid}, {31'd0, 32'h56710001, 1'b1});
    xlate(32'h12340ABC, 32'h56710ABC, 1'b1, 2'd0, "R8 dropped write");

    // R7: rewrite translation value of window 1
    cfg(2'd1, 2'd2, 32'h11110000);
    xlate(32'hABCDF123, 32'h11111123, 1'b1, 2'd1, "R7 new xlat");
    // R7: reserved select 3 changes nothing
    cfg(2'd1, 2'd3, 32'h00000000);
    xlate(32'hABCDF123, 32'h11111123, 1'b1, 2'd1, "R7 sel3");

    // R3: overlap window 2 onto window 0
    cfg(2'd2, 2'd0, 32'h12340000);
    cfg(2'd2, 2'd1, 32'h1234FFFF);
    cfg(2'd2, 2'd2, 32'h77770000);
    xlate(32'h12341111, 32'h56711111, 1'b1, 2'd0, "R3 priority");
    cfg(2'd0, 2'd0, 32'h00010000);
    cfg(2'd0, 2'd1, 32'h0001FFFF);
    xlate(32'h12341111, 32'h77771111, 1'b1, 2'd2, "R3 fallthrough");
    xlate(32'h00018000, 32'h56718000, 1'b1, 2'd0, "R7 moved base");
    xlate(32'hFFFEDCBA, 32'h00000000, 1'b0, 2'd0, "R4 old range");

    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule